// File: doc/BRIEF.md
# Parallel Flash Program Sequencer

This block programs single bytes into a byte-wide parallel flash device and erases the whole device. It drives the device's address, write-data, write-strobe and read-strobe lines itself. A client raises `req_valid` for one cycle while the block is idle. With `req_erase` low the request carries a target address and a data byte. With `req_erase` high it asks for a chip erase.

The block emits the unlock writes and the command writes the device expects. It then writes the data or the erase command and polls the device until two consecutive reads agree. While the device is working, a status bit inside the byte toggles on every read, so consecutive reads differ until the work is done. After a program the block reads the target byte back and compares it with the data. After an erase it reads every address of a configured range and checks for the erased value. A one-cycle `done` pulse ends each operation, and `err` carries its outcome.

Read data is sampled in the same cycle the read strobe and address are driven, so the device path is modelled as combinational. All command addresses, command values, the blank-check range and the poll limit are parameters.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `err`, `fl_we` and `fl_re` are all low.
- R2: A request is accepted only when `busy` is low. A `req_valid` raised while `busy` is high causes no write, no read and no change to the device contents.
- R3: A byte program issues exactly four writes, one per cycle, in this order: (UNLK1_ADDR, UNLK1_DATA), (UNLK2_ADDR, UNLK2_DATA), (PROG_CMD_ADDR, PROG_CMD_DATA), (target address, data byte).
- R4: A chip erase issues exactly six writes, one per cycle, in this order: unlock pair, (ERSEN_CMD_ADDR, ERSEN_CMD_DATA), unlock pair, (ERASE_CMD_ADDR, ERASE_CMD_DATA).
- R5: After the last write the block reads a poll address once per cycle until a read equals the read just before it. The poll address is the target address for a program and BLANK_LO for an erase. A device busy for B reads settles after exactly B+2 poll reads.
- R6: After a program settles, one read of the target address follows. `err` is set if that byte differs from the data byte.
- R7: After an erase settles, every address from BLANK_LO to BLANK_HI is read once, in ascending order. `err` is set if any of those bytes is not 0xFF. Bytes outside that range do not affect `err`.
- R8: If POLL_LIMIT poll reads pass without two consecutive reads agreeing, the operation ends with `err` set. No verify read and no blank-check read follows.
- R9: `done` is high for exactly one cycle per operation while `busy` is high. `busy` is low in the next cycle. `err` keeps its value from that pulse until the next request is accepted.
- R10: `fl_we` and `fl_re` are never high together, and both are low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_erase | input | 1 | 1 = chip erase, 0 = byte program |
| req_addr | input | ADDR_W | Target address of a byte program |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Outcome of the last operation, 1 = failed |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one write per high cycle |
| fl_re | output | 1 | Flash read strobe, data sampled in the same cycle |
| fl_rdata | input | 8 | Flash read data |

## Verification
The bench targets several specific ways the block can fail:
- Settle detection off by one read. A design that treats the first poll read as settled, or compares against a stale value, shows up as a wrong poll-read count for busy lengths from zero to three.
- A second request arriving mid-operation. A design that re-accepts it would write to an address the bench watches.
- Blank-range edges. A bad byte is placed just outside the range, where it must be ignored, and inside it, where it must be caught. A scan that starts or stops one address late fails the ascending-address check.
- Hangs and verify failures. A device that never settles must end in exactly POLL_LIMIT reads with an error. Programming a zero bit back to one must fail the read-back compare.

// File: rtl/flash_seq_pkg.sv
// Shared types of the flash program sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package flash_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_POLL,
        ST_VERIFY,
        ST_BLANK,
        ST_FINISH
    } seq_state_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } seq_op_t;
endpackage

// File: rtl/flash_cmd_steps.sv
// Command step table: for an operation and a write index it gives the
// address and data of that bus write and whether it is the last one.
// Assumes the index never passes the last step of the operation.
module flash_cmd_steps
    import flash_seq_pkg::*;
#(
    parameter int                ADDR_W         = 16,
    parameter int                DATA_W         = 8,
    parameter logic [ADDR_W-1:0] UNLK1_ADDR     = 16'h5555,
    parameter logic [DATA_W-1:0] UNLK1_DATA     = 8'hAA,
    parameter logic [ADDR_W-1:0] UNLK2_ADDR     = 16'h2AAA,
    parameter logic [DATA_W-1:0] UNLK2_DATA     = 8'h55,
    parameter logic [ADDR_W-1:0] PROG_CMD_ADDR  = 16'h5555,
    parameter logic [DATA_W-1:0] PROG_CMD_DATA  = 8'hA0,
    parameter logic [ADDR_W-1:0] ERSEN_CMD_ADDR = 16'h5555,
    parameter logic [DATA_W-1:0] ERSEN_CMD_DATA = 8'h80,
    parameter logic [ADDR_W-1:0] ERASE_CMD_ADDR = 16'h5555,
    parameter logic [DATA_W-1:0] ERASE_CMD_DATA = 8'h10
) (
    input  seq_op_t           op,
    input  logic [2:0]        idx,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] step_addr,
    output logic [DATA_W-1:0] step_data,
    output logic              step_last
);
    // Decode one bus write from the operation and step index.
    always_comb begin
        step_addr = UNLK1_ADDR;
        step_data = UNLK1_DATA;
        step_last = 1'b0;
        if (op == OP_PROG) begin
            unique case (idx)
                3'd1: begin step_addr = UNLK2_ADDR;    step_data = UNLK2_DATA;    end
                3'd2: begin step_addr = PROG_CMD_ADDR; step_data = PROG_CMD_DATA; end
                3'd3: begin step_addr = tgt_addr;      step_data = tgt_data; step_last = 1'b1; end
                default: ;
            endcase
        end else begin
            unique case (idx)
                3'd1, 3'd4: begin step_addr = UNLK2_ADDR;     step_data = UNLK2_DATA;     end
                3'd2:       begin step_addr = ERSEN_CMD_ADDR; step_data = ERSEN_CMD_DATA; end
                3'd5:       begin step_addr = ERASE_CMD_ADDR; step_data = ERASE_CMD_DATA; step_last = 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_busy_poll.sv
// Busy poll comparator: while active, it keeps the previous read byte and
// counts reads. It flags settle when a read equals the one before it, and
// expiry when the limit-th read still has not settled.
// Assumes one read per active cycle and LIMIT of at least 2.
module flash_busy_poll #(
    parameter int DATA_W = 8,
    parameter int LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [DATA_W-1:0] rdata,
    output logic              settled,
    output logic              expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [DATA_W-1:0] prev_q;
    logic              have_q;
    logic [CNT_W-1:0]  cnt_q;

    assign settled = active && have_q && (rdata == prev_q);
    assign expired = active && !settled && (cnt_q == CNT_W'(LIMIT - 1));

    // Track the last read byte and the read count; clear when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            prev_q <= '0;
            have_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            prev_q <= rdata;
            have_q <= 1'b1;
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/flash_prog_seq.sv
// Parallel flash program sequencer top. It accepts a program or erase
// request while idle, then writes the command steps and polls until two
// reads agree. It then verifies the target byte or blank-checks the range
// and pulses done with the error outcome.
// Assumes read data is valid in the cycle fl_re and fl_addr are driven.
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int                ADDR_W         = 16,
    parameter int                DATA_W         = 8,
    parameter logic [ADDR_W-1:0] UNLK1_ADDR     = 16'h5555,
    parameter logic [DATA_W-1:0] UNLK1_DATA     = 8'hAA,
    parameter logic [ADDR_W-1:0] UNLK2_ADDR     = 16'h2AAA,
    parameter logic [DATA_W-1:0] UNLK2_DATA     = 8'h55,
    parameter logic [ADDR_W-1:0] PROG_CMD_ADDR  = 16'h5555,
    parameter logic [DATA_W-1:0] PROG_CMD_DATA  = 8'hA0,
    parameter logic [ADDR_W-1:0] ERSEN_CMD_ADDR = 16'h5555,
    parameter logic [DATA_W-1:0] ERSEN_CMD_DATA = 8'h80,
    parameter logic [ADDR_W-1:0] ERASE_CMD_ADDR = 16'h5555,
    parameter logic [DATA_W-1:0] ERASE_CMD_DATA = 8'h10,
    parameter logic [ADDR_W-1:0] BLANK_LO       = 16'h0000,
    parameter logic [ADDR_W-1:0] BLANK_HI       = 16'hFFFF,
    parameter int                POLL_LIMIT     = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    seq_state_t        state_q;
    seq_op_t           op_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;
    logic [2:0]        idx_q;
    logic [ADDR_W-1:0] scan_q;
    logic              err_q;

    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_data;
    logic              step_last;
    logic              poll_settled;
    logic              poll_expired;
    logic              polling;

    flash_cmd_steps #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .UNLK1_ADDR(UNLK1_ADDR), .UNLK1_DATA(UNLK1_DATA),
        .UNLK2_ADDR(UNLK2_ADDR), .UNLK2_DATA(UNLK2_DATA),
        .PROG_CMD_ADDR(PROG_CMD_ADDR), .PROG_CMD_DATA(PROG_CMD_DATA),
        .ERSEN_CMD_ADDR(ERSEN_CMD_ADDR), .ERSEN_CMD_DATA(ERSEN_CMD_DATA),
        .ERASE_CMD_ADDR(ERASE_CMD_ADDR), .ERASE_CMD_DATA(ERASE_CMD_DATA)
    ) steps_i (
        .op(op_q), .idx(idx_q), .tgt_addr(tgt_addr_q), .tgt_data(tgt_data_q),
        .step_addr(step_addr), .step_data(step_data), .step_last(step_last)
    );

    assign polling = (state_q == ST_POLL);

    flash_busy_poll #(.DATA_W(DATA_W), .LIMIT(POLL_LIMIT)) poll_i (
        .clk(clk), .rst_n(rst_n), .active(polling), .rdata(fl_rdata),
        .settled(poll_settled), .expired(poll_expired)
    );

    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_FINISH);
    assign err   = err_q;
    assign fl_we = (state_q == ST_WRITE);
    assign fl_re = polling || (state_q == ST_VERIFY) || (state_q == ST_BLANK);

    // Steer the flash address and write data by phase.
    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state_q)
            ST_WRITE:  begin fl_addr = step_addr; fl_wdata = step_data; end
            ST_POLL:   fl_addr = (op_q == OP_ERASE) ? BLANK_LO : tgt_addr_q;
            ST_VERIFY: fl_addr = tgt_addr_q;
            ST_BLANK:  fl_addr = scan_q;
            default: ;
        endcase
    end

    // Sequence the operation phases and collect the error outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_PROG;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            idx_q      <= '0;
            scan_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q       <= req_erase ? OP_ERASE : OP_PROG;
                    tgt_addr_q <= req_addr;
                    tgt_data_q <= req_data;
                    idx_q      <= '0;
                    err_q      <= 1'b0;
                    state_q    <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (step_last) state_q <= ST_POLL;
                    else           idx_q   <= idx_q + 1'b1;
                end
                ST_POLL: begin
                    if (poll_expired) begin
                        err_q   <= 1'b1;
                        state_q <= ST_FINISH;
                    end else if (poll_settled) begin
                        scan_q  <= BLANK_LO;
                        state_q <= (op_q == OP_ERASE) ? ST_BLANK : ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (fl_rdata != tgt_data_q) err_q <= 1'b1;
                    state_q <= ST_FINISH;
                end
                ST_BLANK: begin
                    if (fl_rdata != ERASED) err_q <= 1'b1;
                    if (scan_q == BLANK_HI) state_q <= ST_FINISH;
                    else                    scan_q  <= scan_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Protocol checker for the flash program sequencer, bound to the top.
// Assumes a synchronous active-low reset on rst_n.
module flash_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic fl_we,
    input logic fl_re
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_we && !fl_re));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(err));
endmodule

bind flash_prog_seq flash_prog_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .done(done), .err(err), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/flash_prog_seq_tb_top.sv
// Bench: behavioural flash model with toggling busy status plus checks.
module flash_prog_seq_tb_top;
    localparam int         AW = 8;
    localparam logic [7:0] U1A = 8'h55, U1D = 8'hAA, U2A = 8'h2A, U2D = 8'h55;
    localparam logic [7:0] PCA = 8'h55, PCD = 8'hA0;
    localparam logic [7:0] E1A = 8'h55, E1D = 8'h80, E2A = 8'h55, E2D = 8'h10;
    localparam logic [7:0] LO = 8'h20, HI = 8'hDF;
    localparam int         LIMIT = 16;
    localparam int         SPAN = HI - LO + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_erase = 1'b0;
    logic [7:0] req_addr = '0, req_data = '0;
    logic busy, done, err, fl_we, fl_re;
    logic [7:0] fl_addr, fl_wdata, fl_rdata;

    always #4 clk = ~clk;   // 125 MHz

    flash_prog_seq #(
        .ADDR_W(AW), .DATA_W(8),
        .UNLK1_ADDR(U1A), .UNLK1_DATA(U1D), .UNLK2_ADDR(U2A), .UNLK2_DATA(U2D),
        .PROG_CMD_ADDR(PCA), .PROG_CMD_DATA(PCD),
        .ERSEN_CMD_ADDR(E1A), .ERSEN_CMD_DATA(E1D),
        .ERASE_CMD_ADDR(E2A), .ERASE_CMD_DATA(E2D),
        .BLANK_LO(LO), .BLANK_HI(HI), .POLL_LIMIT(LIMIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
        .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // ---------------- flash model ----------------
    logic [7:0] mem [256];
    int  busy_left = 0;
    int  busy_set  = 0;
    bit  tog = 1'b0;
    bit  stuck_busy = 1'b0;
    int  bad_erase_addr = -1;
    logic [7:0] hist_a [6];
    logic [7:0] hist_d [6];
    logic [7:0] wlog_a [16];
    logic [7:0] wlog_d [16];
    logic [7:0] rlog_a [512];
    int  wcnt = 0, rcnt = 0;
    int  overlap_cnt = 0, idle_strobe_cnt = 0;

    wire model_busy = stuck_busy || (busy_left > 0);
    assign fl_rdata = model_busy ? ((~mem[fl_addr] & 8'hBF) | {1'b0, tog, 6'b0})
                                 : mem[fl_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin hist_a[i] = '0; hist_d[i] = '0; end
    end

    always @(posedge clk) begin
        if (fl_we && fl_re) overlap_cnt++;
        if (!busy && (fl_we || fl_re)) idle_strobe_cnt++;
        if (fl_we) begin
            if (wcnt < 16) begin wlog_a[wcnt] = fl_addr; wlog_d[wcnt] = fl_wdata; end
            wcnt++;
            for (int i = 5; i > 0; i--) begin hist_a[i] = hist_a[i-1]; hist_d[i] = hist_d[i-1]; end
            hist_a[0] = fl_addr; hist_d[0] = fl_wdata;
            if (hist_a[3] == U1A && hist_d[3] == U1D && hist_a[2] == U2A && hist_d[2] == U2D &&
                hist_a[1] == PCA && hist_d[1] == PCD) begin
                mem[fl_addr] <= mem[fl_addr] & fl_wdata;
                busy_left <= busy_set;
            end else if (hist_a[5] == U1A && hist_d[5] == U1D && hist_a[4] == U2A && hist_d[4] == U2D &&
                         hist_a[3] == E1A && hist_d[3] == E1D && hist_a[2] == U1A && hist_d[2] == U1D &&
                         hist_a[1] == U2A && hist_d[1] == U2D && hist_a[0] == E2A && hist_d[0] == E2D) begin
                for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
                if (bad_erase_addr >= 0) mem[bad_erase_addr] <= 8'hEF;
                busy_left <= busy_set;
            end
        end
        if (fl_re) begin
            if (rcnt < 512) rlog_a[rcnt] = fl_addr;
            rcnt++;
            if (model_busy) tog <= ~tog;
            if (busy_left > 0) busy_left <= busy_left - 1;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, failures = 0, cycles = 0;
    bit op_err;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Issue one request, optionally poke a second request while busy.
    task automatic run_op(input bit erase, input logic [7:0] a, input logic [7:0] d,
                          input bit poke);
        int waited;
        wcnt = 0; rcnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_erase = erase; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_erase = 1'b0; req_addr = a ^ 8'h80; req_data = 8'h00;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 2000) begin @(negedge clk); waited++; end
        check(done == 1'b1, "R9 done arrives", done, 1);
        op_err = err;
        @(negedge clk);
        check(!done && !busy, "R9 done one cycle then idle", {done, busy}, 0);
    endtask

    task automatic check_prog_writes(input logic [7:0] a, input logic [7:0] d);
        check(wcnt == 4, "R3 program write count", wcnt, 4);
        check(wlog_a[0] == U1A && wlog_d[0] == U1D && wlog_a[1] == U2A && wlog_d[1] == U2D,
              "R3 unlock pair", {wlog_a[0], wlog_a[1]}, {U1A, U2A});
        check(wlog_a[2] == PCA && wlog_d[2] == PCD, "R3 program command", wlog_d[2], PCD);
        check(wlog_a[3] == a && wlog_d[3] == d, "R3 data write", {wlog_a[3], wlog_d[3]}, {a, d});
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !fl_we && !fl_re, "R1 in reset",
              {busy, done, err, fl_we, fl_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !fl_we && !fl_re, "R1 after reset",
              {busy, done, err, fl_we, fl_re}, 0);

        // Erase, device busy for 3 reads
        busy_set = 3;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(wcnt == 6, "R4 erase write count", wcnt, 6);
        check(wlog_a[0] == U1A && wlog_d[0] == U1D && wlog_a[1] == U2A && wlog_d[1] == U2D &&
              wlog_a[2] == E1A && wlog_d[2] == E1D && wlog_a[3] == U1A && wlog_d[3] == U1D &&
              wlog_a[4] == U2A && wlog_d[4] == U2D && wlog_a[5] == E2A && wlog_d[5] == E2D,
              "R4 erase write order", wlog_d[5], E2D);
        check(rcnt == 5 + SPAN, "R5 R7 erase read count", rcnt, 5 + SPAN);
        check(rlog_a[0] == LO && rlog_a[4] == LO, "R5 erase poll address", rlog_a[4], LO);
        begin
            bit asc = 1'b1;
            for (int i = 0; i < SPAN; i++) if (rlog_a[5 + i] != LO + i) asc = 1'b0;
            check(asc, "R7 blank scan ascending LO..HI", asc, 1);
        end
        check(op_err == 1'b0, "R7 clean erase", op_err, 0);

        // Program sweep over every address with varied busy lengths
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d, other_before;
            bit poke, all_tgt;
            d = 8'((a * 37 + 11) & 255);
            busy_set = a % 4;
            poke = (a % 32) == 7;
            other_before = mem[a ^ 8'h80];
            run_op(1'b0, 8'(a), d, poke);
            check_prog_writes(8'(a), d);
            check(rcnt == busy_set + 3, "R5 R6 program read count", rcnt, busy_set + 3);
            all_tgt = 1'b1;
            for (int i = 0; i < rcnt && i < 512; i++) if (rlog_a[i] != 8'(a)) all_tgt = 1'b0;
            check(all_tgt, "R5 R6 reads at target", all_tgt, 1);
            check(op_err == 1'b0 && mem[a] == d, "R6 program verify ok", {op_err, mem[a]}, {1'b0, d});
            if (poke)
                check(mem[a ^ 8'h80] == other_before, "R2 request while busy ignored",
                      mem[a ^ 8'h80], other_before);
        end

        // R9 err holds while idle
        repeat (5) @(negedge clk);
        check(err == 1'b0, "R9 err held idle", err, 0);

        // R6 programming a zero back to one fails the verify
        busy_set = 1;
        run_op(1'b0, 8'h10, 8'hA4, 1'b0);
        check(op_err == 1'b1, "R6 verify mismatch", op_err, 1);
        check(mem[8'h10] == 8'h00, "R6 device kept AND of bits", mem[8'h10], 0);
        repeat (4) @(negedge clk);
        check(err == 1'b1, "R9 err held after fail", err, 1);

        // R8 program never settles
        stuck_busy = 1'b1;
        run_op(1'b0, 8'h33, 8'h00, 1'b0);
        check(op_err == 1'b1, "R8 program timeout error", op_err, 1);
        check(rcnt == LIMIT, "R8 no verify read after timeout", rcnt, LIMIT);
        stuck_busy = 1'b0;

        // R7 bad byte inside the range
        busy_set = 0; bad_erase_addr = 8'h80;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b1, "R7 bad byte in range", op_err, 1);
        check(rcnt == 2 + SPAN, "R7 full scan despite bad byte", rcnt, 2 + SPAN);

        // R7 bad bytes just outside the range are ignored
        bad_erase_addr = LO - 1;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b0, "R7 byte below LO ignored", op_err, 0);
        bad_erase_addr = HI + 1;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b0, "R7 byte above HI ignored", op_err, 0);
        bad_erase_addr = LO;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b1, "R7 bad byte at LO caught", op_err, 1);
        bad_erase_addr = HI;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b1, "R7 bad byte at HI caught", op_err, 1);
        bad_erase_addr = -1;

        // R8 erase never settles
        stuck_busy = 1'b1;
        run_op(1'b1, 8'h00, 8'h00, 1'b0);
        check(op_err == 1'b1, "R8 erase timeout error", op_err, 1);
        check(rcnt == LIMIT, "R8 no blank scan after timeout", rcnt, LIMIT);
        stuck_busy = 1'b0;

        // R10 strobe discipline over the whole run
        check(overlap_cnt == 0, "R10 no write with read", overlap_cnt, 0);
        check(idle_strobe_cnt == 0, "R10 no strobe while idle", idle_strobe_cnt, 0);

        finish_run();
    end
endmodule